// File: doc/BRIEF.md
# Unaligned Memory Access Splitter

This block sits between a processor load/store port and a 32-bit memory bus that only takes naturally aligned byte, halfword and word transfers. The processor hands over one request: address, size, direction, a sign flag and write data. An aligned byte, halfword or word passes through as one bus transfer. A misaligned halfword or word, or an aligned doubleword, is broken into a short run of aligned pieces. Read pieces are reassembled little-endian, and a single done pulse closes the request.

The control is a three-state machine. `ST_IDLE` waits for a request. On *accept*, it moves to `ST_XFER`, or straight to `ST_FINISH` when the request is illegal. `ST_XFER` presents one piece at a time and holds it while the bus stalls. On *last beat*, the cycle in which the final piece is accepted, it moves to `ST_FINISH`. Other accepted beats stay in `ST_XFER` with the next piece. `ST_FINISH` pulses done, plus fault if the request was illegal, and *retires* to `ST_IDLE`.

Each piece is chosen from the current address and the bytes still owed. An odd address gives a byte. A halfword-aligned address gives a halfword. A word-aligned address gives a word when four or more bytes remain, otherwise a halfword or a byte. A strict-mode input turns every misaligned halfword or word into a fault instead of a split.

Top module: `mem_align_splitter`

## Requirements
- R1: An aligned request is done as one bus transfer with no added cycle: a byte at any address, a halfword at an even address, or a word at an address that is a multiple of 4. With bus_ready_i high, done_o rises two cycles after the accepting edge. Size codes on req_size_i and bus_size_o are 0 byte, 1 halfword, 2 word, 3 doubleword (request only). Every bus transfer is naturally aligned to its own size.
- R2: A halfword at an odd address is done as two byte transfers, at addr and then addr+1. It takes exactly one cycle more than an aligned halfword.
- R3: A word at an address equal to 2 modulo 4 is done as two halfword transfers, at addr and then addr+2. It costs one extra cycle.
- R4: A word at an odd address is done as three transfers, in this order: a byte at addr, a halfword at addr+1, a byte at addr+3. It costs two extra cycles.
- R5: While bus_ready_i is low, the presented piece keeps its address, size, strobes and write data. No next piece is issued, so each stall cycle lengthens the request by one cycle.
- R6: A doubleword whose address is a multiple of 4 is done as two word transfers, at addr and addr+4. Any other doubleword raises fault_o together with done_o, one cycle after acceptance, and makes no bus transfer.
- R7: With strict_i high, a misaligned halfword or word raises fault_o with done_o, one cycle after acceptance, and makes no bus transfer. Aligned requests are unaffected.
- R8: Each write piece drives its own address and its write flag. Strobe bit i selects byte lane i, the lane for address bits [1:0] equal to i. Only the lanes of that piece are strobed. The lanes carry the request's data bytes for that piece.
- R9: Load results are little-endian: the byte at the lowest address lands in rdata_o[7:0]. rdata_o is valid while done_o is high.
- R10: done_o is a one-cycle pulse, given once per request, in the cycle after the last piece is accepted. req_ready_o is high only in ST_IDLE. A request presented while busy is ignored and causes no bus transfer.
- R11: For byte and halfword loads with req_signed_i high, the result is sign-extended to 32 bits from its top bit. Otherwise it is zero-extended. Bits 63:32 of rdata_o are zero for all loads other than doubleword.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| strict_i | input | 1 | Fault misaligned halfword/word instead of splitting |
| req_valid_i | input | 1 | Request present |
| req_ready_o | output | 1 | Block idle, request will be taken |
| req_addr_i | input | AW | Byte address of the request |
| req_size_i | input | 2 | 0 byte, 1 halfword, 2 word, 3 doubleword |
| req_write_i | input | 1 | 1 store, 0 load |
| req_signed_i | input | 1 | Sign-extend byte/halfword load result |
| req_wdata_i | input | 64 | Store data, first byte in bits 7:0 |
| done_o | output | 1 | One-cycle completion pulse |
| fault_o | output | 1 | Request was illegal (with done_o) |
| rdata_o | output | 64 | Assembled load result |
| bus_valid_o | output | 1 | Piece presented on the bus |
| bus_ready_i | input | 1 | Bus accepts the presented piece |
| bus_addr_o | output | AW | Piece byte address |
| bus_size_o | output | 2 | Piece size code |
| bus_write_o | output | 1 | Piece is a store |
| bus_strb_o | output | 4 | Byte-lane strobes |
| bus_wdata_o | output | 32 | Store data placed on lanes |
| bus_rdata_i | input | 32 | Load data on lanes, valid with bus_ready_i |

## Verification
The assertions take for granted that the request fields are stable and defined on the accepting edge. They also assume bus_ready_i and bus_rdata_i are defined whenever a piece is presented, and that read data is valid in the same cycle as bus_ready_i. The stimulus changes inputs only on the falling clock edge. It keeps every address inside a 64-byte bus memory that it models itself, and answers reads from that memory in the accepting cycle. Stalls are injected as a fixed count of low-ready cycles before each piece's acceptance. Requests presented during a busy period carry different fields, so any wrongful acceptance would show up as an unexpected bus transfer.

// File: rtl/align_pkg.sv
package align_pkg;
    localparam int LANES     = 4;
    localparam int LANE_W    = $clog2(LANES);
    localparam int BUS_W     = 8 * LANES;
    localparam int REQ_BYTES = 2 * LANES;
    localparam int REQ_W     = 8 * REQ_BYTES;
    localparam int CNT_W     = $clog2(REQ_BYTES) + 1;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_HALF = 2'd1,
        SZ_WORD = 2'd2,
        SZ_DBL  = 2'd3
    } size_e;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_XFER   = 2'd1,
        ST_FINISH = 2'd2
    } state_e;
endpackage

// File: rtl/align_piece.sv
// Chooses the largest naturally aligned piece at the current lane offset
// that does not exceed the bytes still owed.
module align_piece
    import align_pkg::*;
(
    input  logic [LANE_W-1:0] lane_off_i,
    input  logic [CNT_W-1:0]  remain_i,
    output size_e             size_o,
    output logic [CNT_W-1:0]  len_o,
    output logic [LANES-1:0]  strb_o
);
    always_comb begin
        if (lane_off_i[0]) begin
            size_o = SZ_BYTE;
        end else if (lane_off_i[1]) begin
            size_o = (remain_i >= CNT_W'(2)) ? SZ_HALF : SZ_BYTE;
        end else if (remain_i >= CNT_W'(4)) begin
            size_o = SZ_WORD;
        end else if (remain_i >= CNT_W'(2)) begin
            size_o = SZ_HALF;
        end else begin
            size_o = SZ_BYTE;
        end

        unique case (size_o)
            SZ_BYTE: begin
                len_o  = CNT_W'(1);
                strb_o = LANES'(1) << lane_off_i;
            end
            SZ_HALF: begin
                len_o  = CNT_W'(2);
                strb_o = LANES'(3) << lane_off_i;
            end
            default: begin
                len_o  = CNT_W'(4);
                strb_o = '1;
            end
        endcase
    end
endmodule

// File: rtl/align_merge.sv
// Collects read lanes into the little-endian result and applies extension.
module align_merge
    import align_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              capture_i,
    input  logic [LANE_W-1:0] lane_off_i,
    input  logic [CNT_W-1:0]  base_i,
    input  logic [CNT_W-1:0]  len_i,
    input  logic [BUS_W-1:0]  bus_rdata_i,
    input  size_e             ext_size_i,
    input  logic              ext_signed_i,
    output logic [REQ_W-1:0]  result_o
);
    logic [REQ_W-1:0] acc_q, acc_d;
    logic [BUS_W-1:0] lanes;

    assign lanes = bus_rdata_i >> {lane_off_i, 3'b000};

    always_comb begin
        acc_d = acc_q;
        for (int i = 0; i < REQ_BYTES; i++) begin
            for (int k = 0; k < LANES; k++) begin
                if (capture_i && (i == int'(base_i) + k) && (k < int'(len_i)))
                    acc_d[8*i +: 8] = lanes[8*k +: 8];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clear_i) acc_q <= '0;
        else                   acc_q <= acc_d;
    end

    always_comb begin
        unique case (ext_size_i)
            SZ_BYTE: result_o = {{(REQ_W-BUS_W){1'b0}},
                                 {(BUS_W-8){ext_signed_i & acc_q[7]}}, acc_q[7:0]};
            SZ_HALF: result_o = {{(REQ_W-BUS_W){1'b0}},
                                 {(BUS_W-16){ext_signed_i & acc_q[15]}}, acc_q[15:0]};
            SZ_WORD: result_o = {{(REQ_W-BUS_W){1'b0}}, acc_q[BUS_W-1:0]};
            default: result_o = acc_q;
        endcase
    end
endmodule

// File: rtl/mem_align_splitter.sv
module mem_align_splitter
    import align_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             strict_i,
    input  logic             req_valid_i,
    output logic             req_ready_o,
    input  logic [AW-1:0]    req_addr_i,
    input  logic [1:0]       req_size_i,
    input  logic             req_write_i,
    input  logic             req_signed_i,
    input  logic [REQ_W-1:0] req_wdata_i,
    output logic             done_o,
    output logic             fault_o,
    output logic [REQ_W-1:0] rdata_o,
    output logic             bus_valid_o,
    input  logic             bus_ready_i,
    output logic [AW-1:0]    bus_addr_o,
    output logic [1:0]       bus_size_o,
    output logic             bus_write_o,
    output logic [LANES-1:0] bus_strb_o,
    output logic [BUS_W-1:0] bus_wdata_o,
    input  logic [BUS_W-1:0] bus_rdata_i
);
    state_e            state_q, state_d;
    size_e             req_size, size_q, p_size;
    logic [AW-1:0]     addr_q;
    logic [CNT_W-1:0]  remain_q, base_q, p_len, req_len;
    logic [LANES-1:0]  p_strb;
    logic [REQ_W-1:0]  wdata_q, wshift;
    logic              write_q, signed_q, fault_q;
    logic              accept, req_fault, beat, last_beat;

    assign req_size  = size_e'(req_size_i);
    assign accept    = (state_q == ST_IDLE) && req_valid_i;
    assign beat      = (state_q == ST_XFER) && bus_ready_i;
    assign last_beat = beat && (p_len == remain_q);
    assign req_len   = CNT_W'(1) << req_size_i;

    always_comb begin
        req_fault = 1'b0;
        if (req_size == SZ_DBL && req_addr_i[LANE_W-1:0] != '0)
            req_fault = 1'b1;
        if (strict_i && req_size == SZ_HALF && req_addr_i[0])
            req_fault = 1'b1;
        if (strict_i && req_size == SZ_WORD && req_addr_i[LANE_W-1:0] != '0)
            req_fault = 1'b1;
    end

    align_piece u_piece (
        .lane_off_i (addr_q[LANE_W-1:0]),
        .remain_i   (remain_q),
        .size_o     (p_size),
        .len_o      (p_len),
        .strb_o     (p_strb)
    );

    align_merge u_merge (
        .clk          (clk),
        .rst_n        (rst_n),
        .clear_i      (accept),
        .capture_i    (beat && !write_q),
        .lane_off_i   (addr_q[LANE_W-1:0]),
        .base_i       (base_q),
        .len_i        (p_len),
        .bus_rdata_i  (bus_rdata_i),
        .ext_size_i   (size_q),
        .ext_signed_i (signed_q),
        .result_o     (rdata_o)
    );

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (accept)    state_d = req_fault ? ST_FINISH : ST_XFER;
            ST_XFER:   if (last_beat) state_d = ST_FINISH;
            ST_FINISH:                state_d = ST_IDLE;
            default:                  state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // request datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q   <= '0;
            remain_q <= '0;
            base_q   <= '0;
            size_q   <= SZ_BYTE;
            write_q  <= 1'b0;
            signed_q <= 1'b0;
            fault_q  <= 1'b0;
            wdata_q  <= '0;
        end else if (accept) begin
            addr_q   <= req_addr_i;
            remain_q <= req_len;
            base_q   <= '0;
            size_q   <= req_size;
            write_q  <= req_write_i;
            signed_q <= req_signed_i;
            fault_q  <= req_fault;
            wdata_q  <= req_wdata_i;
        end else if (beat) begin
            addr_q   <= addr_q + AW'(p_len);
            remain_q <= remain_q - p_len;
            base_q   <= base_q + p_len;
        end
    end

    assign wshift = wdata_q >> {base_q, 3'b000};

    // outputs
    always_comb begin
        req_ready_o = (state_q == ST_IDLE);
        done_o      = (state_q == ST_FINISH);
        fault_o     = (state_q == ST_FINISH) && fault_q;
        bus_valid_o = (state_q == ST_XFER);
        bus_addr_o  = addr_q;
        bus_size_o  = p_size;
        bus_write_o = bus_valid_o && write_q;
        bus_strb_o  = bus_valid_o ? p_strb : '0;
        bus_wdata_o = bus_valid_o ? (wshift[BUS_W-1:0] << {addr_q[LANE_W-1:0], 3'b000}) : '0;
    end

    assert_natural_align_R1: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> (bus_size_o == 2'd0) ||
                        (bus_size_o == 2'd1 && !bus_addr_o[0]) ||
                        (bus_size_o == 2'd2 && bus_addr_o[1:0] == 2'b00));

    assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o && !bus_ready_i) |=> bus_valid_o && $stable(bus_addr_o) &&
            $stable(bus_size_o) && $stable(bus_strb_o) && $stable(bus_wdata_o));

    assert_dbl_fault_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && req_size_i == 2'd3 && req_addr_i[1:0] != 2'b00)
            |=> fault_o && done_o && !bus_valid_o);

    assert_strict_fault_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid_i && req_ready_o && strict_i && req_size_i == 2'd1 && req_addr_i[0])
            |=> fault_o && !bus_valid_o);

    assert_strobe_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_valid_o |-> $countones(bus_strb_o) == (32'd1 << bus_size_o));

    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    assert_busy_no_accept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_valid_o || done_o) |-> !req_ready_o);
endmodule

// File: tb/tb_mem_align_splitter.sv
module tb_mem_align_splitter;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        strict_i;
    logic        req_valid_i;
    logic        req_ready_o;
    logic [31:0] req_addr_i;
    logic [1:0]  req_size_i;
    logic        req_write_i;
    logic        req_signed_i;
    logic [63:0] req_wdata_i;
    logic        done_o, fault_o;
    logic [63:0] rdata_o;
    logic        bus_valid_o, bus_ready_i;
    logic [31:0] bus_addr_o;
    logic [1:0]  bus_size_o;
    logic        bus_write_o;
    logic [3:0]  bus_strb_o;
    logic [31:0] bus_wdata_o, bus_rdata_i;

    always #2 clk = ~clk;

    mem_align_splitter dut (.*);

    logic [7:0] mem [64];
    int checks = 0;
    int fails  = 0;
    int q_addr[$];
    int q_size[$];

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic summary();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R10 watchdog expired actual=1 expected=0");
        summary();
        $finish;
    end

    // expected piece list, derived case by case from the requirements
    task automatic plan(input int a, input int sz);
        q_addr.delete();
        q_size.delete();
        case (sz)
            0: begin q_addr.push_back(a); q_size.push_back(0); end
            1: if (a % 2 == 1) begin
                   q_addr.push_back(a);   q_size.push_back(0);
                   q_addr.push_back(a+1); q_size.push_back(0);
               end else begin
                   q_addr.push_back(a);   q_size.push_back(1);
               end
            2: if (a % 4 == 0) begin
                   q_addr.push_back(a);   q_size.push_back(2);
               end else if (a % 4 == 2) begin
                   q_addr.push_back(a);   q_size.push_back(1);
                   q_addr.push_back(a+2); q_size.push_back(1);
               end else begin
                   q_addr.push_back(a);   q_size.push_back(0);
                   q_addr.push_back(a+1); q_size.push_back(1);
                   q_addr.push_back(a+3); q_size.push_back(0);
               end
            default: begin
                   q_addr.push_back(a);   q_size.push_back(2);
                   q_addr.push_back(a+4); q_size.push_back(2);
               end
        endcase
    endtask

    task automatic do_req(input int a, input int sz, input bit wr, input bit sg,
                          input logic [63:0] wd, input int stall, input bit noise,
                          input bit exp_fault, input string tag);
        logic [63:0] exp_val;
        int n, pi, wait_cnt, cycle, exp_cycle;
        bit got_done;
        int nb;
        nb = 1 << sz;
        exp_val = '0;
        for (int k = 0; k < nb; k++) exp_val[8*k +: 8] = mem[(a + k) % 64];
        if (sg && sz == 0 && exp_val[7])  exp_val[31:8]  = '1;
        if (sg && sz == 1 && exp_val[15]) exp_val[31:16] = '1;
        if (exp_fault) begin
            q_addr.delete(); q_size.delete();
        end else plan(a, sz);
        n = q_addr.size();
        exp_cycle = exp_fault ? 1 : n * (stall + 1) + 1;

        @(negedge clk);
        chk(req_ready_o == 1'b1, "R10", "ready when idle", req_ready_o, 1);
        req_valid_i = 1'b1; req_addr_i = a; req_size_i = sz[1:0];
        req_write_i = wr; req_signed_i = sg; req_wdata_i = wd;
        @(negedge clk);
        req_valid_i = 1'b0;
        cycle = 1; pi = 0; wait_cnt = 0; got_done = 0;
        while (!got_done && cycle < 200) begin
            bus_ready_i = 1'b0;
            bus_rdata_i = '0;
            if (noise && !done_o) begin
                req_valid_i = 1'b1; req_addr_i = 32'd40; req_size_i = 2'd2;
                req_write_i = 1'b1; req_wdata_i = 64'hDEAD_BEEF;
                chk(req_ready_o == 1'b0, "R10", "ready while busy", req_ready_o, 0);
            end else req_valid_i = 1'b0;
            if (bus_valid_o) begin
                if (pi >= n) begin
                    chk(1'b0, tag, "unexpected bus transfer", bus_addr_o, 0);
                end else begin
                    int pa, plen, off;
                    logic [3:0]  es;
                    logic [31:0] ew, mask;
                    pa = q_addr[pi]; plen = 1 << q_size[pi]; off = pa - a;
                    es = 4'(((1 << plen) - 1) << (pa % 4));
                    ew = '0; mask = '0;
                    for (int k = 0; k < plen; k++) begin
                        ew[8*((pa%4)+k) +: 8]   = wd[8*(off+k) +: 8];
                        mask[8*((pa%4)+k) +: 8] = 8'hFF;
                    end
                    if (wait_cnt == 0) begin
                        chk(bus_addr_o == 32'(pa), tag, "piece address", bus_addr_o, pa);
                        chk(bus_size_o == q_size[pi][1:0], tag, "piece size", bus_size_o, q_size[pi]);
                        chk(bus_strb_o == es, "R8", "piece strobes", bus_strb_o, es);
                        chk(bus_write_o == wr, "R8", "piece direction", bus_write_o, wr);
                        if (wr) chk((bus_wdata_o & mask) == ew, "R8", "piece data",
                                    bus_wdata_o & mask, ew);
                    end
                    if (wait_cnt < stall) begin
                        wait_cnt++;
                    end else begin
                        bus_ready_i = 1'b1;
                        for (int k = 0; k < plen; k++) begin
                            if (wr) mem[(pa + k) % 64] = wd[8*(off+k) +: 8];
                        end
                        for (int l = 0; l < 4; l++)
                            bus_rdata_i[8*l +: 8] = mem[((pa / 4) * 4 + l) % 64];
                        pi++;
                        wait_cnt = 0;
                    end
                end
            end
            if (done_o) begin
                got_done = 1;
                req_valid_i = 1'b0;
                chk(cycle == exp_cycle, tag, "done cycle", cycle, exp_cycle);
                chk(fault_o == exp_fault, tag, "fault flag", fault_o, exp_fault);
                chk(pi == n, tag, "piece count", pi, n);
                if (!wr && !exp_fault)
                    chk(rdata_o == exp_val, tag, "load result", rdata_o, exp_val);
            end else begin
                @(negedge clk);
                cycle++;
            end
        end
        if (!got_done) chk(1'b0, tag, "done never seen", 0, 1);
        @(negedge clk);
        bus_ready_i = 1'b0;
        bus_rdata_i = '0;
        chk(done_o == 1'b0, "R10", "done lasts one cycle", done_o, 0);
    endtask

    initial begin
        for (int i = 0; i < 64; i++) mem[i] = 8'((i * 37 + 5) % 256);
        rst_n = 1'b0; strict_i = 1'b0; req_valid_i = 1'b0; req_addr_i = '0;
        req_size_i = '0; req_write_i = 1'b0; req_signed_i = 1'b0; req_wdata_i = '0;
        bus_ready_i = 1'b0; bus_rdata_i = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(bus_valid_o == 1'b0, "R10", "reset bus idle", bus_valid_o, 0);
        chk(done_o == 1'b0, "R10", "reset done low", done_o, 0);
        chk(req_ready_o == 1'b1, "R10", "reset ready", req_ready_o, 1);

        // R1 / R9 aligned requests
        do_req(5,  0, 0, 0, '0, 0, 0, 0, "R1");
        do_req(6,  1, 0, 0, '0, 0, 0, 0, "R1");
        do_req(8,  2, 0, 0, '0, 0, 0, 0, "R9");
        // R2 odd halfword, signed and unsigned
        do_req(9,  1, 0, 0, '0, 0, 0, 0, "R2");
        do_req(3,  1, 0, 1, '0, 0, 0, 0, "R2");
        // R3 halfword-aligned word
        do_req(10, 2, 0, 0, '0, 0, 0, 0, "R3");
        // R4 odd words, with and without stalls (R5)
        do_req(13, 2, 0, 0, '0, 0, 0, 0, "R4");
        do_req(15, 2, 0, 0, '0, 2, 0, 0, "R5");
        // R8 stores, read back little-endian (R9)
        do_req(21, 2, 1, 0, 64'h0000_0000_A1B2_C3D4, 0, 0, 0, "R8");
        do_req(21, 2, 0, 0, '0, 0, 0, 0, "R9");
        do_req(31, 1, 1, 0, 64'h0000_0000_0000_9E8F, 1, 0, 0, "R8");
        do_req(31, 1, 0, 1, '0, 0, 0, 0, "R11");
        // R6 doublewords
        do_req(36, 3, 1, 0, 64'h1122_3344_5566_7788, 0, 0, 0, "R6");
        do_req(36, 3, 0, 0, '0, 1, 0, 0, "R6");
        do_req(34, 3, 0, 0, '0, 0, 0, 1, "R6");
        // R11 byte extension
        mem[50] = 8'hC7;
        do_req(50, 0, 0, 1, '0, 0, 0, 0, "R11");
        do_req(50, 0, 0, 0, '0, 0, 0, 0, "R11");
        // R7 strict mode
        strict_i = 1'b1;
        do_req(2,  2, 0, 0, '0, 0, 0, 1, "R7");
        do_req(7,  1, 1, 0, 64'h55, 0, 0, 1, "R7");
        do_req(12, 2, 0, 0, '0, 0, 0, 0, "R7");
        strict_i = 1'b0;
        // R10 requests while busy are ignored
        do_req(17, 2, 0, 0, '0, 1, 1, 0, "R10");
        do_req(40, 2, 0, 0, '0, 0, 0, 0, "R10");

        summary();
        $finish;
    end
endmodule